// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block is a loadable shift register that converts a parallel word into a serial bit stream. It runs entirely on a fast system clock. It reproduces the behaviour of a discrete loadable shifter whose shift clock is slow, asynchronous and arrives on ordinary input pins. All control and data inputs are first passed through two-flop synchronisers. A shift is issued when the combined shift clock rises, as seen in the system clock domain.

The combined shift clock is the OR of two pins. One pin is the shift clock and the other is an active-low enable, and the two may be swapped. While the load input is low, the parallel word is taken into the register and appears on the serial output; the load overrides everything else. The last stage drives the serial output and its inverse. To chain several devices, connect the serial output of one device to the serial input of the next. The chain then streams one long word, starting with the most significant bit of the last device.

Top module: `piso_shifter`

## Requirements
- R1: While `load_ni` is low, the register takes `par_i` every system cycle, whatever the state of `sclk_i`, `sen_ni` and `ser_i`.
- R2: While `load_ni` is high, each rising edge of the combined shift clock shifts the register by one place. `ser_i` enters stage 0 and stage n moves to stage n+1, so a loaded word leaves the block with bit 7 first.
- R3: The combined shift clock is `sclk_i | sen_ni`. The two pins are interchangeable, so either one can act as the clock while the other is held low as the enable.
- R4: While `sen_ni` is high, toggling `sclk_i` causes no shift and the register contents are kept.
- R5: `ser_o` is stage 7 and `ser_no` is always its inverse. During a load, `ser_o` follows bit 7 of `par_i`.
- R6: If `sen_ni` rises while `sclk_i` is low, this is a combined clock edge and causes one shift.
- R7: If `load_ni` is released while `sclk_i` and `sen_ni` are both low, the release causes no shift. The first shift comes with the next rising edge of the combined clock.
- R8: Two devices chained through `ser_o` to `ser_i` shift out 16 bits: the 8 bits of the downstream device first, then the 8 bits of the upstream device, each most significant bit first.
- R9: Reset (`rst_ni` low) clears all stages to zero and sets the edge history to 1. After reset, `ser_o` is 0 and `ser_no` is 1.
- R10: Latency is counted from the system cycle in which a new `sclk_i` level is first sampled. A shift becomes visible on `ser_o` at the third rising edge of `clk_i` from that cycle, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Parallel load, active low, asynchronous to clk_i |
| par_i | input | WIDTH | Parallel data word, bit WIDTH-1 leaves first |
| ser_i | input | 1 | Serial data into stage 0 |
| sclk_i | input | 1 | Shift clock pin, ORed with sen_ni |
| sen_ni | input | 1 | Clock enable pin, active low, ORed with sclk_i |
| ser_o | output | 1 | Last-stage serial output |
| ser_no | output | 1 | Inverse of ser_o |

## Verification
The assertions check four things on every cycle:
- a load cycle leaves the register equal to the synchronised parallel word;
- a shift pulse moves the register by exactly one place;
- the register stays unchanged in every other cycle;
- the edge detector never fires twice in a row, never fires while the enable is held high, and never fires on a load release with the combined clock low.

Only the bench scenarios can show the effects seen from outside the block. These are the most-significant-bit-first order of the serial stream, the swapping of clock and enable pins, the exact three-edge latency, and the 16-bit order of a two-device chain.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2
  } shift_mode_e;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_act_i,
  input  logic sclk_s_i,
  input  logic sen_n_s_i,
  output logic shift_o
);
  logic or_w;
  logic hist_q;

  assign or_w = sclk_s_i | sen_n_s_i;

  // history tracks OR level during load too, so a release never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b1;
    else         hist_q <= or_w;
  end

  assign shift_o = !load_act_i && !hist_q && or_w;

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> !shift_o);

  p_enable_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sen_n_s_i && $past(sen_n_s_i)) |-> !shift_o);

  p_release_no_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(load_act_i) && !load_act_i && !or_w) |-> !shift_o);
endmodule

// File: rtl/piso_core.sv
module piso_core
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  shift_mode_e      mode_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      unique case (mode_i)
        MODE_LOAD:  q_q <= par_i;
        MODE_SHIFT: q_q <= {q_q[WIDTH-2:0], ser_i};
        default:    q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;

  p_load_takes_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD) |=> (q_o == $past(par_i)));

  p_shift_one_place_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SHIFT) |=> (q_o == {$past(q_o[WIDTH-2:0]), $past(ser_i)}));

  p_hold_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> $stable(q_o));
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  input  logic             sclk_i,
  input  logic             sen_ni,
  output logic             ser_o,
  output logic             ser_no
);
  localparam int unsigned SW = WIDTH + 4;
  // layout: {load_n, sclk, sen_n, ser, par}; idle values keep the combined clock high
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {(WIDTH+1){1'b0}}};

  logic [SW-1:0]    sync_d, sync_q;
  logic             load_n_s, sclk_s, sen_n_s, ser_s;
  logic [WIDTH-1:0] par_s;
  logic             load_act, shift_w;
  shift_mode_e      mode;
  logic [WIDTH-1:0] q_w;

  assign sync_d = {load_ni, sclk_i, sen_ni, ser_i, par_i};

  piso_sync #(
    .WIDTH  (SW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {load_n_s, sclk_s, sen_n_s, ser_s, par_s} = sync_q;
  assign load_act = !load_n_s;

  piso_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_act_i(load_act),
    .sclk_s_i  (sclk_s),
    .sen_n_s_i (sen_n_s),
    .shift_o   (shift_w)
  );

  always_comb begin
    if (load_act)     mode = MODE_LOAD;
    else if (shift_w) mode = MODE_SHIFT;
    else              mode = MODE_HOLD;
  end

  piso_core #(
    .WIDTH(WIDTH)
  ) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .par_i (par_s),
    .ser_i (ser_s),
    .q_o   (q_w)
  );

  // load is transparent to the output
  assign ser_o  = load_act ? par_s[WIDTH-1] : q_w[WIDTH-1];
  assign ser_no = ~ser_o;

  p_reset_clear_r9: assert property (@(posedge clk_i)
    !rst_ni |=> (q_w == '0));
endmodule

// File: tb/tb_piso_shifter.sv
module tb_piso_shifter;
  localparam int W = 8;
  localparam int SET = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1;
  logic [W-1:0] par_a = '0, par_b = '0;
  logic ser_in = 1'b0;
  logic sclk = 1'b1;
  logic sen_n = 1'b0;
  logic out_a, out_an, out_b, out_bn;

  int n_tests = 0;
  int n_fail = 0;
  logic [W-1:0] mdl_a = '0, mdl_b = '0;
  bit use_en = 1'b0;

  always #4 clk = ~clk;

  piso_shifter #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .par_i(par_a),
    .ser_i(ser_in), .sclk_i(sclk), .sen_ni(sen_n),
    .ser_o(out_a), .ser_no(out_an));

  piso_shifter #(.WIDTH(W)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .par_i(par_b),
    .ser_i(out_a), .sclk_i(sclk), .sen_ni(sen_n),
    .ser_o(out_b), .ser_no(out_bn));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_a(input string req);
    chk(req, out_a, mdl_a[W-1]);
    chk({req, " inverse R5"}, out_an, ~mdl_a[W-1]);
  endtask

  function automatic logic [W-1:0] shl(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    par_a = a; par_b = b; load_n = 1'b0;
    step(SET);
    mdl_a = a; mdl_b = b;
    chk("R1 load word", out_a, a[W-1]);
    chk("R5 load follows D7", out_an, ~a[W-1]);
    load_n = 1'b1;
    step(SET);
  endtask

  // clock line idle high, enable line low; roles swap with use_en
  task automatic set_roles(input bit en_as_clk);
    if (en_as_clk) begin
      sen_n = 1'b1; step(2); sclk = 1'b0; step(2);
    end else begin
      sclk = 1'b1; step(2); sen_n = 1'b0; step(2);
    end
    use_en = en_as_clk;
  endtask

  task automatic pulse(input logic s);
    ser_in = s;
    if (use_en) begin sen_n = 1'b0; step(SET); sen_n = 1'b1; end
    else        begin sclk  = 1'b0; step(SET); sclk  = 1'b1; end
    step(SET);
    mdl_b = shl(mdl_b, mdl_a[W-1]);
    mdl_a = shl(mdl_a, s);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(SET);
    chk("R9 reset ser_o", out_a, 1'b0);
    chk("R9 reset ser_no", out_an, 1'b1);

    // R2 directed readout, MSB first
    do_load(8'hB4, 8'h00);
    for (int i = 0; i < W; i++) begin pulse(1'b0); chk_a("R2 shift"); end

    // R1 load overrides toggling clock
    par_a = 8'h3C; load_n = 1'b0; step(2);
    sclk = 1'b0; ser_in = 1'b1; step(SET); sclk = 1'b1; step(SET);
    mdl_a = 8'h3C;
    chk("R1 load overrides clock", out_a, 1'b0);
    load_n = 1'b1; step(SET);
    chk_a("R1 no shift after load");

    // R4 hold with enable high
    do_load(8'hA6, 8'h00);
    sen_n = 1'b1; step(2);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; ser_in = ~ser_in; step(SET); sclk = 1'b1; step(SET);
      chk_a("R4 hold");
    end
    sen_n = 1'b0; step(2);
    for (int i = 0; i < W; i++) begin pulse(1'b1); chk_a("R4 contents kept"); end

    // R6 enable as clock, R3 swapped roles
    do_load(8'h5A, 8'h00);
    set_roles(1'b1);
    chk_a("R3 role swap no edge");
    for (int i = 0; i < W; i++) begin pulse(i[0]); chk_a("R6 enable edge shifts"); end
    set_roles(1'b0);
    chk_a("R3 role restore no edge");

    // R7 load release with combined clock low
    sclk = 1'b0; sen_n = 1'b0; step(2);
    par_a = 8'h80; load_n = 1'b0; step(SET);
    load_n = 1'b1; step(SET);
    mdl_a = 8'h80;
    chk("R7 no shift on release", out_a, 1'b1);
    ser_in = 1'b0; sclk = 1'b1; step(SET);
    mdl_a = shl(mdl_a, 1'b0);
    chk("R7 next edge shifts", out_a, 1'b0);

    // R10 latency: Q7=1, Q6=0
    do_load(8'h80, 8'h00);
    sclk = 1'b0; step(SET);
    sclk = 1'b1;
    step(2);
    chk("R10 not before third edge", out_a, 1'b1);
    step(1);
    chk("R10 at third edge", out_a, 1'b0);
    mdl_a = shl(mdl_a, 1'b0);
    step(SET);

    // random words, random clock role, random serial input
    for (int it = 0; it < 16; it++) begin
      logic [W-1:0] w;
      w = W'($urandom());
      do_load(w, 8'h00);
      set_roles(bit'($urandom() & 1));
      for (int i = 0; i < W + 2; i++) begin
        pulse(1'($urandom()));
        chk_a(use_en ? "R3 random enable-clock" : "R2 random shift");
      end
      set_roles(1'b0);
    end

    // R8 two-device cascade
    do_load(8'hC3, 8'h96);
    for (int i = 0; i < 2 * W; i++) begin
      logic exp_bit;
      exp_bit = (i < W) ? 8'h96 >> (W - 1 - i) : 8'hC3 >> (2 * W - 1 - i);
      chk("R8 cascade", out_b, exp_bit);
      chk("R8 cascade inverse", out_bn, ~exp_bit);
      pulse(1'b0);
    end
    chk("R8 model agree", out_b, mdl_b[W-1]);

    // R9 reset mid-stream
    do_load(8'hFF, 8'hFF);
    rst_n = 1'b0; step(2);
    chk("R9 reset clears", out_a, 1'b0);
    rst_n = 1'b1; step(SET);
    chk("R9 after reset", out_an, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule